// File: doc/BRIEF.md
# Current-Limit Trip Code Calibrator

This block runs once at power-up and finds the 6-bit code that sets a current-limit trip level. It drives a reference code to an external DAC and starts that code at zero. The code goes up by one after every step period. An external comparator reports when the analog reference has passed a voltage set by a resistor. The comparator result is synchronized and read only at the end of each step, after the reference has had time to settle. The first step that reads high freezes the ramp, and that code is stored as the trip code.

When the code is stored, a done output goes high and releases soft-start. Two flags describe the stored code:
- If the ramp reaches the top code and the comparator has not tripped, current limiting is disabled.
- A stored code at or below a small threshold gives an effective limit of zero.

The result holds until asynchronous reset or a synchronous restart request.

Top module: `trip_code_cal`

## Requirements
- R1: While rst_ni is low, ref_code_o, trip_code_o, done_o, lim_off_o and zero_lim_o are all 0.
- R2: After reset or restart, ref_code_o starts at 0. It rises by exactly one every STEP_CYCLES clock cycles as long as no trip is sampled. After j*STEP_CYCLES cycles it reads j.
- R3: cmp_i passes through a two-flop synchronizer. It is sampled only in the last cycle of each step. A one-cycle high pulse of cmp_i at the start of a step has no effect on the result.
- R4: If the comparator is sampled high while the ramp is at code k, then trip_code_o = k. done_o rises exactly (k+1)*STEP_CYCLES cycles after reset release or the restart edge, and is low one cycle earlier.
- R5: Once done_o is high, ref_code_o, trip_code_o, done_o and both flags stay constant whatever cmp_i does, until reset or restart.
- R6: If no trip is sampled through code 63, done_o rises 64*STEP_CYCLES cycles after the start. In that case trip_code_o = 63, lim_off_o = 1 and zero_lim_o = 0.
- R7: After a trip, zero_lim_o = 1 if the trip code is at most ZERO_MAX (default 10), and 0 for codes above it. lim_off_o is 0 after a trip. Both flags are 0 while done_o is low.
- R8: restart_i high at a clock edge clears done_o and both flags, sets ref_code_o to 0, and starts a new calibration timed from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Synchronous request to run calibration again |
| cmp_i | input | 1 | Asynchronous comparator: high once the reference exceeds the set voltage |
| ref_code_o | output | 6 | Code driven to the reference DAC |
| trip_code_o | output | 6 | Stored trip code |
| done_o | output | 1 | Calibration complete; releases soft-start |
| lim_off_o | output | 1 | Current limit disabled (set voltage above full scale) |
| zero_lim_o | output | 1 | Stored code gives an effective zero limit |

## Verification
The bench builds the block with STEP_CYCLES = 8 and keeps the default ZERO_MAX = 10. A full 64-step ramp therefore lasts 512 cycles. This makes it cheap to check every set code, including the overrun past 63, and to count done timing to the exact cycle. The comparator model trips at a chosen set code. Directed runs cover codes 0, 10, 11, 63 and two codes beyond 63. Random set codes, a mid-step glitch and post-done comparator toggling are added through restart.

// File: rtl/trip_cal_pkg.sv
package trip_cal_pkg;
  localparam int unsigned CODE_W = 6;
  typedef logic [CODE_W-1:0] code_t;
  localparam code_t CODE_TOP = '1;
  typedef enum logic {ST_RAMP, ST_HELD} cal_st_e;
endpackage

// File: rtl/tc_sync.sv
module tc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q[g] <= 1'b0;
        else         sr_q[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q[g] <= 1'b0;
        else         sr_q[g] <= sr_q[g-1];
    end
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/tc_step_timer.sv
module tc_step_timer #(
  parameter int unsigned STEP_CYCLES = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic last_o
);
  localparam int unsigned CNT_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign last_o = en_i && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i)   cnt_q <= last_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/tc_ramp_ctrl.sv
module tc_ramp_ctrl
  import trip_cal_pkg::*;
#(
  parameter int unsigned ZERO_MAX = 10
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  restart_i,
  input  logic  step_end_i,
  input  logic  cmp_i,
  output logic  running_o,
  output code_t ref_code_o,
  output code_t trip_code_o,
  output logic  done_o,
  output logic  lim_off_o,
  output logic  zero_lim_o
);
  localparam code_t ZERO_CODE = code_t'(ZERO_MAX);

  cal_st_e st_q;
  code_t   code_q, trip_q;
  logic    off_q, zero_q;

  assign running_o = (st_q == ST_RAMP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_RAMP;
      code_q <= '0;
      trip_q <= '0;
      off_q  <= 1'b0;
      zero_q <= 1'b0;
    end else if (restart_i) begin
      st_q   <= ST_RAMP;
      code_q <= '0;
      trip_q <= '0;
      off_q  <= 1'b0;
      zero_q <= 1'b0;
    end else if (running_o && step_end_i) begin
      if (cmp_i) begin
        st_q   <= ST_HELD;
        trip_q <= code_q;
        zero_q <= (code_q <= ZERO_CODE);
      end else if (code_q == CODE_TOP) begin
        // set level above full scale: no limit
        st_q   <= ST_HELD;
        trip_q <= CODE_TOP;
        off_q  <= 1'b1;
      end else begin
        code_q <= code_q + 1'b1;
      end
    end
  end

  assign ref_code_o  = code_q;
  assign trip_code_o = trip_q;
  assign done_o      = (st_q == ST_HELD);
  assign lim_off_o   = off_q;
  assign zero_lim_o  = zero_q;
endmodule

// File: rtl/trip_code_cal.sv
module trip_code_cal
  import trip_cal_pkg::*;
#(
  parameter int unsigned STEP_CYCLES = 100000,
  parameter int unsigned ZERO_MAX    = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              cmp_i,
  output logic [CODE_W-1:0] ref_code_o,
  output logic [CODE_W-1:0] trip_code_o,
  output logic              done_o,
  output logic              lim_off_o,
  output logic              zero_lim_o
);
  logic cmp_s, step_end, running;

  tc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cmp_i),
    .q_o   (cmp_s)
  );

  tc_step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (restart_i),
    .en_i  (running),
    .last_o(step_end)
  );

  tc_ramp_ctrl #(.ZERO_MAX(ZERO_MAX)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (restart_i),
    .step_end_i (step_end),
    .cmp_i      (cmp_s),
    .running_o  (running),
    .ref_code_o (ref_code_o),
    .trip_code_o(trip_code_o),
    .done_o     (done_o),
    .lim_off_o  (lim_off_o),
    .zero_lim_o (zero_lim_o)
  );
endmodule

// File: rtl/trip_code_cal_chk.sv
module trip_code_cal_chk
  import trip_cal_pkg::*;
#(
  parameter int unsigned ZERO_MAX = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              restart_i,
  input logic [CODE_W-1:0] ref_code_o,
  input logic [CODE_W-1:0] trip_code_o,
  input logic              done_o,
  input logic              lim_off_o,
  input logic              zero_lim_o
);
  a_r2_step_by_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_i |=> (ref_code_o == $past(ref_code_o)) ||
                   (ref_code_o == $past(ref_code_o) + 1'b1));

  a_r4_trip_is_ref: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> trip_code_o == ref_code_o);

  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !restart_i |=> done_o && $stable(trip_code_o) &&
                             $stable(lim_off_o) && $stable(zero_lim_o));

  a_r6_off_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lim_off_o |-> done_o && trip_code_o == CODE_TOP);

  a_r7_zero_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_lim_o |-> done_o && !lim_off_o && trip_code_o <= code_t'(ZERO_MAX));

  a_r7_flags_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !lim_off_o && !zero_lim_o);

  a_r8_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !done_o && ref_code_o == '0);
endmodule

bind trip_code_cal trip_code_cal_chk #(.ZERO_MAX(ZERO_MAX)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .restart_i  (restart_i),
  .ref_code_o (ref_code_o),
  .trip_code_o(trip_code_o),
  .done_o     (done_o),
  .lim_off_o  (lim_off_o),
  .zero_lim_o (zero_lim_o)
);

// File: tb/trip_code_cal_bench.sv
`timescale 1ns/1ps
module trip_code_cal_bench;
  localparam int STEP = 8;
  localparam int ZMAX = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       restart = 1'b0;
  logic       glitch = 1'b0;
  logic       cmp;
  logic [5:0] ref_code, trip_code;
  logic       done, lim_off, zero_lim;
  int         set_code = 200;
  int         checks = 0;
  int         errors = 0;
  int unsigned seed = 32'h5eed_1234;

  always #2.5 clk = ~clk;

  // comparator model: trips once reference code reaches set code
  assign cmp = glitch | (int'(ref_code) >= set_code);

  trip_code_cal #(.STEP_CYCLES(STEP), .ZERO_MAX(ZMAX)) u_trip_code_cal (
    .clk_i(clk), .rst_ni(rst_n), .restart_i(restart), .cmp_i(cmp),
    .ref_code_o(ref_code), .trip_code_o(trip_code), .done_o(done),
    .lim_off_o(lim_off), .zero_lim_o(zero_lim)
  );

  function automatic int exp_code(int s);  return (s > 63) ? 63 : s; endfunction
  function automatic bit exp_off(int s);   return s > 63; endfunction
  function automatic bit exp_zero(int s);  return (s <= 63) && (s <= ZMAX); endfunction
  function automatic int exp_edges(int s); return (exp_code(s) + 1) * STEP; endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic step_edges(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // start: 0 = reset, 1 = restart; glitch_on pulses cmp at a step start
  task automatic run_case(int s, bit use_restart, bit glitch_on);
    int k = exp_code(s);
    int n = exp_edges(s);
    int j = k / 2;
    int t = 0;
    set_code = s;
    @(negedge clk);
    if (use_restart) begin
      restart = 1'b1;
      @(posedge clk); #1;
      restart = 1'b0;
      chk("R8 restart clears done", done, 0);
      chk("R8 restart code zero", ref_code, 0);
    end else begin
      rst_n = 1'b0;
      #1;
      chk("R1 reset done", done, 0);
      chk("R1 reset ref", ref_code, 0);
      chk("R1 reset trip", trip_code, 0);
      chk("R1 reset flags", {lim_off, zero_lim}, 0);
      @(negedge clk);
      rst_n = 1'b1;
    end
    if (glitch_on && k >= 2) begin
      step_edges(STEP); t = STEP;
      glitch = 1'b1;
      step_edges(1); t++;
      glitch = 1'b0;
    end
    if (j * STEP > t) begin
      step_edges(j * STEP - t); t = j * STEP;
      chk("R2 ramp code", ref_code, j);
    end
    step_edges(n - 1 - t);
    chk("R4 done low one cycle early", done, 0);
    chk("R7 flags low before done", {lim_off, zero_lim}, 0);
    step_edges(1);
    chk(exp_off(s) ? "R6 done at overrun" : "R4 done edge", done, 1);
    chk(glitch_on ? "R3 glitch ignored" : (exp_off(s) ? "R6 trip top" : "R4 trip code"),
        trip_code, k);
    chk("R6 limit off flag", lim_off, exp_off(s));
    chk("R7 zero flag", zero_lim, exp_zero(s));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    #1;
    chk("R1 reset done at start", done, 0);
    // directed corners
    run_case(0, 1'b0, 1'b0);
    run_case(10, 1'b0, 1'b0);
    run_case(11, 1'b0, 1'b0);
    run_case(63, 1'b0, 1'b0);
    run_case(64, 1'b0, 1'b0);
    run_case(90, 1'b1, 1'b0);
    run_case(20, 1'b1, 1'b1);
    // hold after done
    set_code = 0;
    step_edges(3 * STEP);
    set_code = 200;
    step_edges(3 * STEP);
    chk("R5 done held", done, 1);
    chk("R5 trip held", trip_code, 20);
    chk("R5 ref held", ref_code, 20);
    chk("R5 flags held", {lim_off, zero_lim}, 0);
    // restart in the middle of a ramp
    set_code = 40;
    @(negedge clk); restart = 1'b1; @(negedge clk); restart = 1'b0;
    step_edges(5 * STEP);
    run_case(5, 1'b1, 1'b0);
    // random set codes
    for (int i = 0; i < 16; i++) begin
      int s = int'($urandom(seed) % 72);
      seed = seed + 32'd7919;
      run_case(s, 1'b1, (i % 4) == 0);
    end
    summary();
  end
endmodule